// File: doc/BRIEF.md
# Microprogrammed Controller-Sequencer

This block is the control unit of a small accumulator machine. It does not decode instructions with gates. It keeps every control word in a 16-entry control store and walks a 4-bit micro-address through that store, one word per clock. Each instruction takes six timing states. The first three states run a shared fetch routine. At the end of the third state, an opcode-indexed start table presets the micro-address to the first word of the instruction's own three-word routine. The last three states then step through that routine. After the sixth state the micro-address returns to zero and the next fetch begins.

Routines that need fewer than three real steps are padded with the no-operation word. Because of this padding, every instruction costs exactly six cycles. A halt opcode stops the sequencing. The block then drives the no-operation word and raises a halted flag until the next reset.

The datapath that consumes the 12-bit control word lies outside this block. The 12 control-word bits, from bit 11 down to bit 0, are:

- bit 11: increment program counter
- bit 10: enable program counter onto the bus
- bit 9: load memory address, active low
- bit 8: enable RAM, active low
- bit 7: load instruction register, active low
- bit 6: enable instruction operand, active low
- bit 5: load accumulator, active low
- bit 4: enable accumulator
- bit 3: subtract select
- bit 2: enable adder
- bit 1: load B, active low
- bit 0: load output, active low

Top module: `useq_ctrl`

## Requirements
- R1: While reset is asserted, `tstate` is 6'b000001 (first timing state), `ctrl_word` is 12'h5E3 and `halted` is 0.
- R2: In the first three timing states of every instruction, `ctrl_word` is 12'h5E3, 12'hBE3 and 12'h263, in that order.
- R3: The opcode is sampled only at the rising edge that ends the third timing state. LDA=4'b0000 starts at micro-address 3, ADD=4'b0001 at 6, SUB=4'b0010 at 9 and OUT=4'b1110 at 12. Opcode changes during states four to six have no effect on the words issued.
- R4: In timing states four to six, the words issued are: LDA 1A3,2C3,3E3; ADD 1A3,2E1,3C7; SUB 1A3,2E1,3CF; OUT 3F2,3E3,3E3 (hex).
- R5: `tstate` is one-hot, with bit k marking timing state k+1. It advances one state per clock. After the sixth state it returns to the first state, with the micro-address back at zero.
- R6: The no-operation word is 12'h3E3. Any opcode from 4'b0011 to 4'b1101 runs three no-operation words in states four to six.
- R7: If the opcode is HLT=4'b1111 at the end of the third state, then from the next cycle `halted` is 1, `tstate` is 0 and `ctrl_word` is 12'h3E3. These values hold whatever the opcode does, until reset.
- R8: Reset assertion is asynchronous, and reset release passes through a two-stage synchronizer. The first timing state lasts until the third rising edge after `rst_n` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| opcode | input | 4 | Instruction opcode field, sampled at the end of the third timing state |
| ctrl_word | output | 12 | Control word for the current timing state |
| tstate | output | 6 | One-hot timing state, zero while halted |
| halted | output | 1 | Set after a halt opcode until reset |

## Verification
Every output is a combinational function of registers that change on the rising edge. A new timing state and its word therefore appear right after an edge. A halt opcode present at the edge that ends the third state shows on all three outputs from the following cycle. The driver starts each instruction just after the edge that enters the first state, and queues six expected words, one per cycle. The monitor compares one queued item per falling edge, so each check lands in the middle of the cycle its result belongs to. After a reset release, the driver waits two rising edges before it queues anything, which matches the synchronizer delay.

// File: rtl/useq_pkg.sv
package useq_pkg;

  localparam int UA_W    = 4;
  localparam int OP_W    = 4;
  localparam int WORD_W  = 12;
  localparam int NSTATES = 6;
  localparam int PRESET_STATE = 2;   // zero-based index of the third timing state

  localparam logic [OP_W-1:0] OP_LDA = 4'b0000;
  localparam logic [OP_W-1:0] OP_ADD = 4'b0001;
  localparam logic [OP_W-1:0] OP_SUB = 4'b0010;
  localparam logic [OP_W-1:0] OP_OUT = 4'b1110;
  localparam logic [OP_W-1:0] OP_HLT = 4'b1111;

  localparam logic [WORD_W-1:0] W_NOP = 12'h3E3;

  // Routine entry points in the control store
  localparam logic [UA_W-1:0] UA_LDA  = 4'h3;
  localparam logic [UA_W-1:0] UA_ADD  = 4'h6;
  localparam logic [UA_W-1:0] UA_SUB  = 4'h9;
  localparam logic [UA_W-1:0] UA_OUT  = 4'hC;
  localparam logic [UA_W-1:0] UA_IDLE = 4'hD;  // three no-op words D..F

  function automatic logic [WORD_W-1:0] store_word(input logic [UA_W-1:0] ua);
    logic [WORD_W-1:0] w;
    case (ua)
      4'h0: w = 12'h5E3;  // program counter to address register
      4'h1: w = 12'hBE3;  // advance program counter
      4'h2: w = 12'h263;  // memory to instruction register
      4'h3: w = 12'h1A3;  // operand to address register
      4'h4: w = 12'h2C3;  // memory to accumulator
      4'h5: w = W_NOP;
      4'h6: w = 12'h1A3;
      4'h7: w = 12'h2E1;  // memory to B
      4'h8: w = 12'h3C7;  // sum to accumulator
      4'h9: w = 12'h1A3;
      4'hA: w = 12'h2E1;
      4'hB: w = 12'h3CF;  // difference to accumulator
      4'hC: w = 12'h3F2;  // accumulator to output
      default: w = W_NOP;
    endcase
    return w;
  endfunction

endpackage

// File: rtl/useq_start_rom.sv
module useq_start_rom
  import useq_pkg::*;
(
  input  logic [OP_W-1:0] opcode,
  output logic [UA_W-1:0] start_addr,
  output logic            is_halt
);

  always_comb begin
    is_halt = (opcode == OP_HLT);
    case (opcode)
      OP_LDA:  start_addr = UA_LDA;
      OP_ADD:  start_addr = UA_ADD;
      OP_SUB:  start_addr = UA_SUB;
      OP_OUT:  start_addr = UA_OUT;
      default: start_addr = UA_IDLE;
    endcase
  end

endmodule

// File: rtl/useq_ctrl_rom.sv
module useq_ctrl_rom
  import useq_pkg::*;
(
  input  logic [UA_W-1:0]   uaddr,
  output logic [WORD_W-1:0] word
);

  always_comb word = store_word(uaddr);

endmodule

// File: rtl/useq_sequencer.sv
module useq_sequencer
  import useq_pkg::*;
#(
  parameter int NT    = NSTATES,
  parameter int PRE_T = PRESET_STATE
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [UA_W-1:0] start_addr,
  input  logic            is_halt,
  output logic [UA_W-1:0] uaddr,
  output logic [NT-1:0]   ring,
  output logic            halted
);

  logic [UA_W-1:0] uaddr_q, uaddr_d;
  logic [NT-1:0]   ring_q, ring_d;
  logic            halted_q, halted_d;
  logic            adv;

  assign adv = !halted_q;

  always_comb begin
    ring_d   = ring_q;
    uaddr_d  = uaddr_q;
    halted_d = halted_q;
    if (adv) begin
      ring_d = {ring_q[NT-2:0], ring_q[NT-1]};
      if (ring_q[PRE_T]) begin
        if (is_halt) begin
          halted_d = 1'b1;
          ring_d   = ring_q;
        end else begin
          uaddr_d = start_addr;
        end
      end else if (ring_q[NT-1]) begin
        uaddr_d = '0;
      end else begin
        uaddr_d = uaddr_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ring_q   <= {{(NT-1){1'b0}}, 1'b1};
      uaddr_q  <= '0;
      halted_q <= 1'b0;
    end else begin
      ring_q   <= ring_d;
      uaddr_q  <= uaddr_d;
      halted_q <= halted_d;
    end
  end

  assign uaddr  = uaddr_q;
  assign ring   = ring_q;
  assign halted = halted_q;

  // R5: timing ring stays one-hot
  p_ring_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(ring_q));

  // R5: first state always fetches from address zero
  p_fetch_from_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ring_q[0] && !halted_q) |-> (uaddr_q == '0));

  // R3: preset at the end of the third state
  p_preset_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ring_q[PRE_T] && !halted_q && !is_halt) |=> (uaddr_q == $past(start_addr)));

  // R5: wrap after the last state
  p_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ring_q[NT-1] && !halted_q) |=> (ring_q[0] && uaddr_q == '0));

  // R7: halt freezes the sequencer
  p_halt_freeze_r7: assert property (@(posedge clk) disable iff (!rst_n)
    halted_q |=> (halted_q && $stable(uaddr_q) && $stable(ring_q)));

endmodule

// File: rtl/useq_ctrl.sv
module useq_ctrl
  import useq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [OP_W-1:0]   opcode,
  output logic [WORD_W-1:0] ctrl_word,
  output logic [NSTATES-1:0] tstate,
  output logic              halted
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   rst_int_n;
  logic [UA_W-1:0]        start_addr;
  logic                   is_halt;
  logic [UA_W-1:0]        uaddr;
  logic [NSTATES-1:0]     ring;
  logic                   halted_s;
  logic [WORD_W-1:0]      rom_word;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_int_n = sync_q[SYNC_STAGES-1];

  useq_start_rom u_start (
    .opcode     (opcode),
    .start_addr (start_addr),
    .is_halt    (is_halt)
  );

  useq_sequencer u_seq (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .start_addr (start_addr),
    .is_halt    (is_halt),
    .uaddr      (uaddr),
    .ring       (ring),
    .halted     (halted_s)
  );

  useq_ctrl_rom u_rom (
    .uaddr (uaddr),
    .word  (rom_word)
  );

  always_comb begin
    ctrl_word = halted_s ? W_NOP : rom_word;
    tstate    = halted_s ? '0 : ring;
    halted    = halted_s;
  end

  // R7: halt only arises at the end of the third state with a halt opcode
  p_halt_entry_r7: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(halted) |-> ($past(tstate[PRESET_STATE]) && $past(opcode) == OP_HLT));

  // R2: the third state always loads the instruction register
  p_third_fetch_r2: assert property (@(posedge clk) disable iff (!rst_int_n)
    tstate[PRESET_STATE] |-> (ctrl_word == 12'h263));

endmodule

// File: tb/useq_ctrl_bench.sv
`timescale 1ns/1ps
module useq_ctrl_bench;

  typedef struct {
    logic [11:0] word;
    logic [5:0]  ts;
    logic        hlt;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  opcode = 4'b0000;
  logic [11:0] ctrl_word;
  logic [5:0]  tstate;
  logic        halted;

  int n_checks = 0;
  int n_fail   = 0;
  exp_t q[$];

  always #2.5 clk = ~clk;

  useq_ctrl u_useq_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .opcode    (opcode),
    .ctrl_word (ctrl_word),
    .tstate    (tstate),
    .halted    (halted)
  );

  function automatic logic [35:0] routine(input logic [3:0] op);
    case (op)
      4'b0000: return {12'h1A3, 12'h2C3, 12'h3E3};
      4'b0001: return {12'h1A3, 12'h2E1, 12'h3C7};
      4'b0010: return {12'h1A3, 12'h2E1, 12'h3CF};
      4'b1110: return {12'h3F2, 12'h3E3, 12'h3E3};
      default: return {12'h3E3, 12'h3E3, 12'h3E3};
    endcase
  endfunction

  task automatic push(input logic [11:0] w, input logic [5:0] t, input logic h, input string tag);
    exp_t e;
    e.word = w; e.ts = t; e.hlt = h; e.tag = tag;
    q.push_back(e);
  endtask

  function automatic string rtag(input logic [3:0] op);
    if (op == 4'b0000 || op == 4'b0001 || op == 4'b0010 || op == 4'b1110) return "R4";
    return "R6";
  endfunction

  // called just after the edge that enters the first timing state
  task automatic run_instr(input logic [3:0] op, input bit scramble);
    logic [35:0] r;
    r = routine(op);
    opcode = op;
    push(12'h5E3, 6'b000001, 1'b0, "R2");
    push(12'hBE3, 6'b000010, 1'b0, "R2");
    push(12'h263, 6'b000100, 1'b0, "R2");
    push(r[35:24], 6'b001000, 1'b0, scramble ? "R3" : rtag(op));
    push(r[23:12], 6'b010000, 1'b0, scramble ? "R3" : rtag(op));
    push(r[11:0],  6'b100000, 1'b0, "R5");
    repeat (3) @(posedge clk);
    #1;
    if (scramble) opcode = ~op;
    repeat (3) @(posedge clk);
    #1;
  endtask

  task automatic check_reset_state();
    @(negedge clk);
    n_checks++;
    if (tstate !== 6'b000001 || ctrl_word !== 12'h5E3 || halted !== 1'b0) begin
      n_fail++;
      $display("FAIL R1: word=%h ts=%b h=%b expected word=5e3 ts=000001 h=0",
               ctrl_word, tstate, halted);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check_reset_state();
    check_reset_state();
    @(negedge clk);
    rst_n = 1'b1;
    // R8: two synchronizer edges before the ring may move
    repeat (2) @(posedge clk);
    #1;
  endtask

  // monitor
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      n_checks++;
      if (ctrl_word !== e.word || tstate !== e.ts || halted !== e.hlt) begin
        n_fail++;
        $display("FAIL %s: word=%h ts=%b h=%b expected word=%h ts=%b h=%b",
                 e.tag, ctrl_word, tstate, halted, e.word, e.ts, e.hlt);
      end
    end
  end

  initial begin
    #(200000 * 5);
    n_fail++;
    n_checks++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #1;
    check_reset_state();                 // R1
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);           // R8 release latency
    #1;
    run_instr(4'b0000, 1'b0);            // LDA, R4
    run_instr(4'b0001, 1'b0);            // ADD
    run_instr(4'b0010, 1'b0);            // SUB
    run_instr(4'b1110, 1'b0);            // OUT
    run_instr(4'b0101, 1'b0);            // undefined, R6
    run_instr(4'b0001, 1'b1);            // ADD with late opcode change, R3
    run_instr(4'b1101, 1'b0);            // undefined, R6
    run_instr(4'b0010, 1'b1);            // SUB with late change, R3
    // halt, R7
    opcode = 4'b1111;
    push(12'h5E3, 6'b000001, 1'b0, "R2");
    push(12'hBE3, 6'b000010, 1'b0, "R2");
    push(12'h263, 6'b000100, 1'b0, "R2");
    for (int i = 0; i < 5; i++) push(12'h3E3, 6'b000000, 1'b1, "R7");
    repeat (3) @(posedge clk);
    #1;
    for (int i = 0; i < 5; i++) begin
      opcode = (i % 2 == 0) ? 4'b0001 : 4'b1110;
      @(posedge clk);
      #1;
    end
    wait (q.size() == 0);
    do_reset();                          // R1 clears halt, R8
    run_instr(4'b1110, 1'b0);
    run_instr(4'b0000, 1'b0);
    wait (q.size() == 0);
    @(negedge clk);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule